// File: doc/BRIEF.md
# Predicated Stack Load-Multiple Sequencer

This block expands one stack-relative compressed load into a series of element loads, so that a single instruction can pop several registers off the stack. On a start pulse it captures the stack base address, the immediate offset, an element size code, the destination register (with an optional redirection entry), the vector length and a pair of predicate masks, one per side. It then walks two element indices: a source index that steps the immediate offset on the memory side, and a destination index that steps the register number on the register-file side. Each side that is marked vector skips the positions whose own predicate bit is clear. A side that is scalar stays at element zero.

For every surviving pair of indices the block issues one read to memory through a request/ready handshake, waits for the read data, and writes it into the register file in the same cycle the data arrives. The sequence stops as soon as either index runs past the vector length. A one-cycle done pulse then returns the block to idle. Memory, register file and the source of the predicate masks live outside the block.

Top module: `stkld_seq`

## Requirements
- R1: While reset is held and afterwards while idle, `mem_req`, `rf_we`, `done` and `busy` are all low.
- R2: Each read request carries the address `base + (offset + i) * size`, where the size is 4 bytes for `size_sel` 0, 8 bytes for 1, and 16 bytes for 2 and 3. `offset` is unsigned, and the sum wraps at the address width.
- R3: When `src_vec` is high, the source index skips every position whose `src_pred` bit (bit k for element k) is 0, and advances by one after each transfer.
- R4: When `dst_vec` is high, the destination index skips every position whose `dst_pred` bit is 0, and advances by one after each transfer. Each write goes to register `(rbase + j) mod 64`.
- R5: A side whose vector flag is low keeps its index at 0 for the whole sequence, whatever its predicate mask holds.
- R6: The sequence ends as soon as either index reaches the vector length. If skipping runs an index to that limit, no further request is issued. A vector length of 0 gives no transfer.
- R7: With both vector flags low and a nonzero vector length, exactly one transfer is made, at element 0 on both sides.
- R8: `rbase` is `rd_map_idx` when `rd_map_en` is high, and otherwise `rd_idx` zero-extended to 6 bits. The stack side is never redirected.
- R9: At most one read is outstanding. `mem_req` stays low from the accepting edge until the read data arrives, and while a request waits for `mem_ready` its address does not change.
- R10: `rf_we` is high only in a cycle where `mem_rvalid` is high during a read, and `rf_wdata` carries that cycle's `mem_rdata`.
- R11: `done` is high for exactly one cycle after the last transfer, or after the decision that there is none. The block is idle in the next cycle, and a `start` seen while busy is ignored.
- R12: A vector length above the element count `NEL` (32) is treated as `NEL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a sequence (taken only while idle) |
| base_addr | input | 32 | Stack base address |
| imm_off | input | 8 | Unsigned element offset from the immediate |
| size_sel | input | 2 | Element size code: 0 word, 1 doubleword, 2/3 quadword |
| rd_idx | input | 5 | Destination register from the instruction |
| rd_map_en | input | 1 | Destination redirection entry is active |
| rd_map_idx | input | 6 | Redirected destination register |
| vlen | input | 6 | Vector length (clamped to NEL) |
| src_pred | input | 32 | Source predicate mask |
| dst_pred | input | 32 | Destination predicate mask |
| src_vec | input | 1 | Source side is vector |
| dst_vec | input | 1 | Destination side is vector |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | 32 | Read address |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 6 | Register-file write index |
| rf_wdata | output | 64 | Register-file write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The walk is tried with every pairing of vector and scalar sides. Source-only vector runs separate offset stepping from register stepping, destination-only runs do the reverse, and the all-scalar case shows that the loop stops after one transfer. Sparse masks, all-zero masks and masks whose last set bit lies past the vector length tell apart correct skipping, early termination and a stray request beyond the limit. Random masks, lengths, sizes and redirection settings, under random memory stalls and read latencies, check the address and register order against an independently written loop model. Directed runs cover a length of zero, a length above 32, register-index wraparound and a start pulse while busy.

// File: rtl/stkld_pkg.sv
package stkld_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEEK,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } seq_state_e;

  // element size code to log2(bytes)
  function automatic logic [2:0] size_shift(input logic [1:0] sel);
    logic [2:0] s;
    case (sel)
      2'd0:    s = 3'd2;
      2'd1:    s = 3'd3;
      default: s = 3'd4;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/stkld_scan.sv
// Finds the next element index for one side of the walk.
module stkld_scan #(
  parameter int NEL = 32,
  parameter int IW  = $clog2(NEL + 1)
) (
  input  logic [IW-1:0]  cur_idx,
  input  logic [NEL-1:0] pred,
  input  logic           is_vec,
  input  logic [IW-1:0]  limit,
  output logic [IW-1:0]  nxt_idx,
  output logic           in_range
);

  // lowest set position at or above 'from'; NEL when none
  function automatic logic [IW-1:0] first_from(input logic [NEL-1:0] m,
                                               input logic [IW-1:0]  from);
    logic [IW-1:0] r;
    r = IW'(NEL);
    for (int k = NEL - 1; k >= 0; k--) begin
      if (m[k] && (k >= int'(from))) r = IW'(k);
    end
    return r;
  endfunction

  assign nxt_idx  = is_vec ? first_from(pred, cur_idx) : cur_idx;
  assign in_range = (nxt_idx < limit);

endmodule

// File: rtl/stkld_agen.sv
// Stack-side address: base + (offset + index) scaled by element size.
module stkld_agen #(
  parameter int AW    = 32,
  parameter int OFF_W = 8,
  parameter int IW    = 6
) (
  input  logic [AW-1:0]    base,
  input  logic [OFF_W-1:0] off,
  input  logic [IW-1:0]    idx,
  input  logic [2:0]       shift,
  output logic [AW-1:0]    addr
);

  function automatic logic [AW-1:0] elem_addr(input logic [AW-1:0]    b,
                                              input logic [OFF_W-1:0] o,
                                              input logic [IW-1:0]    i,
                                              input logic [2:0]       sh);
    logic [AW-1:0] slot;
    slot = AW'(o) + AW'(i);
    return b + (slot << sh);
  endfunction

  assign addr = elem_addr(base, off, idx, shift);

endmodule

// File: rtl/stkld_ctrl.sv
// Sequencer state machine.
module stkld_ctrl
  import stkld_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       both_hit,
  input  logic       any_vec,
  input  logic       mem_ready,
  input  logic       mem_rvalid,
  output seq_state_e state,
  output logic       load_o,
  output logic       take_o,
  output logic       fire_o
);

  seq_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (start) nxt = ST_SEEK;
      ST_SEEK: nxt = both_hit ? ST_REQ : ST_DONE;
      ST_REQ:  if (mem_ready) nxt = ST_WAIT;
      ST_WAIT: if (mem_rvalid) nxt = any_vec ? ST_SEEK : ST_DONE;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign load_o = (state == ST_IDLE) && start;
  assign take_o = (state == ST_SEEK) && both_hit;
  assign fire_o = (state == ST_WAIT) && mem_rvalid;

endmodule

// File: rtl/stkld_seq.sv
module stkld_seq
  import stkld_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int OFF_W = 8,
  parameter int NEL   = 32,
  parameter int RW    = 6,
  parameter int IW    = $clog2(NEL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    base_addr,
  input  logic [OFF_W-1:0] imm_off,
  input  logic [1:0]       size_sel,
  input  logic [RW-2:0]    rd_idx,
  input  logic             rd_map_en,
  input  logic [RW-1:0]    rd_map_idx,
  input  logic [IW-1:0]    vlen,
  input  logic [NEL-1:0]   src_pred,
  input  logic [NEL-1:0]   dst_pred,
  input  logic             src_vec,
  input  logic             dst_vec,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_ready,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  output logic             rf_we,
  output logic [RW-1:0]    rf_waddr,
  output logic [DW-1:0]    rf_wdata,
  output logic             busy,
  output logic             done
);

  localparam int NSIDE = 2;  // 0: stack side, 1: register side
  localparam logic [IW-1:0] VL_CAP = IW'(NEL);

  // captured operands
  logic [AW-1:0]    base_q;
  logic [OFF_W-1:0] off_q;
  logic [2:0]       shift_q;
  logic [RW-1:0]    rbase_q;
  logic [IW-1:0]    vl_q;
  logic [NEL-1:0]   pred_q [NSIDE];
  logic             vec_q  [NSIDE];
  logic [IW-1:0]    idx_q  [NSIDE];

  // named events for checking
  seq_state_e    state;
  logic          load_ev, take_ev, fire_ev, both_hit, any_vec;
  logic          wait_st;
  logic [IW-1:0] nxt_idx [NSIDE];
  logic          hit     [NSIDE];
  logic [IW-1:0] src_i, dst_j;

  function automatic logic [IW-1:0] clamp_vl(input logic [IW-1:0] v);
    return (v > VL_CAP) ? VL_CAP : v;
  endfunction

  function automatic logic [RW-1:0] pick_rbase(input logic          en,
                                               input logic [RW-1:0] mapped,
                                               input logic [RW-2:0] raw);
    return en ? mapped : {1'b0, raw};
  endfunction

  // per-side index scanners
  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    stkld_scan #(.NEL(NEL), .IW(IW)) u_scan (
      .cur_idx (idx_q[g]),
      .pred    (pred_q[g]),
      .is_vec  (vec_q[g]),
      .limit   (vl_q),
      .nxt_idx (nxt_idx[g]),
      .in_range(hit[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx_q[g]  <= '0;
        pred_q[g] <= '0;
        vec_q[g]  <= 1'b0;
      end else if (load_ev) begin
        idx_q[g]  <= '0;
        pred_q[g] <= (g == 0) ? src_pred : dst_pred;
        vec_q[g]  <= (g == 0) ? src_vec  : dst_vec;
      end else if (take_ev) begin
        idx_q[g]  <= nxt_idx[g];
      end else if (fire_ev && vec_q[g]) begin
        idx_q[g]  <= idx_q[g] + IW'(1);
      end
    end
  end

  assign both_hit = hit[0] && hit[1];
  assign any_vec  = vec_q[0] || vec_q[1];

  stkld_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .both_hit  (both_hit),
    .any_vec   (any_vec),
    .mem_ready (mem_ready),
    .mem_rvalid(mem_rvalid),
    .state     (state),
    .load_o    (load_ev),
    .take_o    (take_ev),
    .fire_o    (fire_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      off_q   <= '0;
      shift_q <= 3'd2;
      rbase_q <= '0;
      vl_q    <= '0;
    end else if (load_ev) begin
      base_q  <= base_addr;
      off_q   <= imm_off;
      shift_q <= size_shift(size_sel);
      rbase_q <= pick_rbase(rd_map_en, rd_map_idx, rd_idx);
      vl_q    <= clamp_vl(vlen);
    end
  end

  stkld_agen #(.AW(AW), .OFF_W(OFF_W), .IW(IW)) u_agen (
    .base (base_q),
    .off  (off_q),
    .idx  (idx_q[0]),
    .shift(shift_q),
    .addr (mem_addr)
  );

  assign src_i    = idx_q[0];
  assign dst_j    = idx_q[1];
  assign wait_st  = (state == ST_WAIT);
  assign mem_req  = (state == ST_REQ);
  assign rf_we    = fire_ev;
  assign rf_waddr = rbase_q + RW'(idx_q[1]);
  assign rf_wdata = mem_rdata;
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);

endmodule

// File: rtl/stkld_seq_chk.sv
module stkld_seq_chk #(
  parameter int AW = 32,
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rvalid,
  input logic          rf_we,
  input logic          wait_st,
  input logic          take_ev,
  input logic          src_vec_q,
  input logic          dst_vec_q,
  input logic [IW-1:0] src_i,
  input logic [IW-1:0] dst_j,
  input logic [IW-1:0] vl_q
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !rf_we && !done));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> !mem_req);

  p_no_req_in_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wait_st |-> !mem_req);

  p_we_with_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (mem_rvalid && wait_st));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_issue_in_bounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((src_i < vl_q) && (dst_j < vl_q)));

  p_scalar_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !src_vec_q) |-> (src_i == '0));

  p_scalar_dst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dst_vec_q) |-> (dst_j == '0));

  p_single_shot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !src_vec_q && !dst_vec_q) |=> done);

  p_take_leads_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev |=> mem_req);

endmodule

bind stkld_seq stkld_seq_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .mem_req   (mem_req),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_rvalid(mem_rvalid),
  .rf_we     (rf_we),
  .wait_st   (wait_st),
  .take_ev   (take_ev),
  .src_vec_q (vec_q[0]),
  .dst_vec_q (vec_q[1]),
  .src_i     (src_i),
  .dst_j     (dst_j),
  .vl_q      (vl_q)
);

// File: tb/sim_stkld_seq.sv
`timescale 1ns/1ps
module sim_stkld_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [7:0]  imm_off = '0;
  logic [1:0]  size_sel = '0;
  logic [4:0]  rd_idx = '0;
  logic        rd_map_en = 1'b0;
  logic [5:0]  rd_map_idx = '0;
  logic [5:0]  vlen = '0;
  logic [31:0] src_pred = '0, dst_pred = '0;
  logic        src_vec = 1'b0, dst_vec = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ready = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        rf_we;
  logic [5:0]  rf_waddr;
  logic [63:0] rf_wdata;
  logic        busy, done;

  always #4 clk = ~clk;

  stkld_seq u0 (.*);

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] e_addr [64];
  logic [5:0]  e_reg  [64];
  int          n_exp;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_word(input logic [31:0] a);
    return {a ^ 32'h5A3C_0F00, ~a};
  endfunction

  // independent model of the walk
  function automatic void build_expect(input logic [31:0] b, input logic [7:0] off,
      input logic [1:0] sz, input logic [4:0] rd, input logic ren, input logic [5:0] ridx,
      input logic [5:0] v, input logic [31:0] sp, input logic [31:0] dp,
      input logic sv, input logic dv);
    int lim, i, j, mult;
    logic [5:0] rb;
    lim  = (v > 6'd32) ? 32 : int'(v);
    mult = (sz == 2'd0) ? 4 : (sz == 2'd1) ? 8 : 16;
    rb   = ren ? ridx : {1'b0, rd};
    i = 0; j = 0; n_exp = 0;
    while (1) begin
      if (sv) while (i < lim && !sp[i]) i++;
      if (dv) while (j < lim && !dp[j]) j++;
      if (i >= lim || j >= lim) break;
      e_addr[n_exp] = b + 32'((int'(off) + i) * mult);
      e_reg[n_exp]  = rb + 6'(j);
      n_exp++;
      if (!sv && !dv) break;
      if (sv) i++;
      if (dv) j++;
    end
  endfunction

  task automatic run_op(input string tag, input logic [31:0] b, input logic [7:0] off,
      input logic [1:0] sz, input logic [4:0] rd, input logic ren, input logic [5:0] ridx,
      input logic [5:0] v, input logic [31:0] sp, input logic [31:0] dp,
      input logic sv, input logic dv, input bit poke);
    int kreq, kwr, cyc, lat;
    bit pend;
    logic [31:0] raddr;
    build_expect(b, off, sz, rd, ren, ridx, v, sp, dp, sv, dv);
    @(negedge clk);
    base_addr = b; imm_off = off; size_sel = sz; rd_idx = rd;
    rd_map_en = ren; rd_map_idx = ridx; vlen = v;
    src_pred = sp; dst_pred = dp; src_vec = sv; dst_vec = dv; start = 1'b1;
    kreq = 0; kwr = 0; cyc = 0; lat = 0; pend = 1'b0; raddr = '0;
    forever begin
      @(negedge clk);
      cyc++;
      // drive memory side
      mem_rvalid = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rvalid = 1'b1; mem_rdata = mem_word(raddr); pend = 1'b0;
        end else lat--;
      end
      mem_ready = ($urandom % 3) != 0;
      if (poke && cyc == 3) begin
        start = 1'b1; base_addr = ~b; vlen = 6'd0; // R11: must be ignored
      end else start = 1'b0;
      #1;
      if (mem_req && mem_ready) begin
        check(!pend, tag, "R9 request while read outstanding", 64'(pend), 64'd0);
        check(kreq < n_exp, tag, "R6 extra request", 64'(kreq), 64'(n_exp));
        if (kreq < n_exp)
          check(mem_addr == e_addr[kreq], tag, "R2/R3 read address", 64'(mem_addr), 64'(e_addr[kreq]));
        raddr = mem_addr; pend = 1'b1; lat = int'($urandom % 3); kreq++;
      end
      if (rf_we) begin
        check(mem_rvalid, tag, "R10 write without read data", 64'(mem_rvalid), 64'd1);
        check(kwr < n_exp, tag, "R6 extra write", 64'(kwr), 64'(n_exp));
        if (kwr < n_exp) begin
          check(rf_waddr == e_reg[kwr], tag, "R4/R8 write register", 64'(rf_waddr), 64'(e_reg[kwr]));
          check(rf_wdata == mem_word(e_addr[kwr]), tag, "R10 write data", rf_wdata, mem_word(e_addr[kwr]));
        end
        kwr++;
      end
      if (done) begin
        check(kwr == n_exp && kreq == n_exp, tag, "R6 transfer count", 64'(kwr), 64'(n_exp));
        @(negedge clk);
        mem_rvalid = 1'b0; start = 1'b0;
        #1;
        check(!done && !busy, tag, "R11 done pulse then idle", {62'd0, done, busy}, 64'd0);
        break;
      end
      if (cyc > 3000) begin
        check(1'b0, tag, "R11 sequence never finished", 64'(cyc), 64'd3000);
        break;
      end
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    #1;
    check(!mem_req && !rf_we && !done && !busy, "R1", "outputs in reset",
          {60'd0, mem_req, rf_we, done, busy}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!mem_req && !rf_we && !done && !busy, "R1", "outputs idle after reset",
          {60'd0, mem_req, rf_we, done, busy}, 64'd0);

    // directed corners
    run_op("R6 zero length", 32'h1000, 8'd2, 2'd0, 5'd8, 1'b0, 6'd0, 6'd0,
           '1, '1, 1'b1, 1'b1, 1'b0);
    run_op("R7 both scalar", 32'h2000, 8'd5, 2'd1, 5'd3, 1'b0, 6'd0, 6'd9,
           32'h0, 32'h0, 1'b0, 1'b0, 1'b0);
    run_op("R5 scalar dest", 32'h3000, 8'd1, 2'd0, 5'd10, 1'b0, 6'd0, 6'd8,
           32'b1011_0110, 32'h0, 1'b1, 1'b0, 1'b0);
    run_op("R5 scalar src", 32'h4000, 8'd0, 2'd2, 5'd4, 1'b0, 6'd0, 6'd8,
           32'h0, 32'b1100_1010, 1'b0, 1'b1, 1'b0);
    run_op("R3 sparse both", 32'h5000, 8'd3, 2'd3, 5'd1, 1'b0, 6'd0, 6'd16,
           32'h0000_8421, 32'h0000_F00F, 1'b1, 1'b1, 1'b0);
    run_op("R6 empty src mask", 32'h6000, 8'd0, 2'd0, 5'd2, 1'b0, 6'd0, 6'd12,
           32'h0, '1, 1'b1, 1'b1, 1'b0);
    run_op("R6 bits past length", 32'h6100, 8'd0, 2'd1, 5'd2, 1'b0, 6'd0, 6'd4,
           32'hFFFF_FF02, '1, 1'b1, 1'b1, 1'b0);
    run_op("R12 length clamp", 32'h7000, 8'd0, 2'd0, 5'd0, 1'b0, 6'd0, 6'd45,
           '1, '1, 1'b1, 1'b1, 1'b0);
    run_op("R8 redirect wrap", 32'h8000, 8'd250, 2'd1, 5'd7, 1'b1, 6'd60, 6'd10,
           '1, '1, 1'b1, 1'b1, 1'b0);
    run_op("R4 address wrap", 32'hFFFF_FFF0, 8'd1, 2'd2, 5'd31, 1'b0, 6'd0, 6'd6,
           '1, 32'h2A, 1'b1, 1'b1, 1'b0);
    run_op("R11 start while busy", 32'h9000, 8'd4, 2'd0, 5'd5, 1'b0, 6'd0, 6'd10,
           '1, '1, 1'b1, 1'b1, 1'b1);

    // constrained random
    for (int t = 0; t < 150; t++) begin
      logic [31:0] sp, dp;
      sp = $urandom; dp = $urandom;
      if (t % 5 == 0) sp = sp & $urandom;
      run_op("R2/R3/R4 random", $urandom, 8'($urandom), 2'($urandom), 5'($urandom),
             1'($urandom), 6'($urandom), 6'($urandom % 40), sp, dp,
             1'($urandom), 1'($urandom), (t % 7 == 0));
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule